// File: doc/BRIEF.md
# I2C Register-File Target for a Buck Regulator

This block is an I2C target that gives a two-wire host access to a six-entry control file for a voltage regulator. SCL and SDA are sampled by the system clock. Each line passes through a short synchronizer and then a glitch filter. The filtered levels drive the detection of START, repeated START and STOP. A sequencer tracks the address byte, the register pointer byte and the data bytes. It acknowledges the bytes it accepts by pulling SDA low, and it drives the bits of a read byte onto the open-drain line.

The register file contains the following:
- Two setpoint registers. Each one holds a converter-run bit and a 7-bit voltage code.
- A control register with a discharge enable, a 3-bit ramp-rate code and two mode bits.
- Two fixed identification bytes.
- A monitor byte. It shows the live status inputs together with a sticky "register reset happened" flag.

The fields are exported as plain wires to the regulator control logic. The pointer advances after every data byte, so a host can write or read several registers in one transfer.

Top module: `i2c_regfile_target`

## Requirements
- R1: The target answers only to the 7-bit address 1100000. The R/W bit is bit 0 of the first byte, and all bytes are MSB first. It pulls SDA low in the ACK slot after a matching address byte, after the pointer byte and after every write data byte. For any other address it stays silent, and the bytes that follow have no effect.
- R2: A write (START, address+0, pointer, data, STOP) stores the data in the addressed register. The exported fields decode as follows. Register 0 bit 7 is `run_a_o` and bits 6:0 are `code_a_o`. Register 1 maps to `run_b_o` and `code_b_o` in the same way. In register 2, bit 7 is `dischg_o`, bits 6:4 are `ramp_o` and bits 1:0 are `mode_o`.
- R3: A read runs as follows: the pointer is written, then a repeated START, then address+1. The target then returns the addressed byte MSB first. It pulls SDA low only for zero data bits and for its own ACK slots. A master ACK after a data byte gives the next byte. A master NACK ends the read.
- R4: After reset the registers hold 0xD4, 0xCD, 0x80, 0x85, 0x00 and 0x00 for addresses 0 to 5.
- R5: The pointer increments after each data byte, whether written or read. Consecutive bytes therefore reach consecutive registers.
- R6: Writes to registers 3, 4 and 5 and to any address above 5 are acknowledged and change nothing. Reads from addresses above 5 return 0x00.
- R7: Writing a 1 to register 2 bit 2 restores every register to its reset value. Register 2 bits 3 and 2 always read back 0.
- R8: Monitor bit 2 is set by the soft reset of R7 and is cleared after register 5 has been read. The other monitor bits show `status_i` live, and `status_i[2]` is not used.
- R9: A first byte of the form 00001xxx after a START is not acknowledged. Bytes that follow it before the next START or STOP change no register.
- R10: A pulse on SCL or SDA shorter than `FILT_LEN` system-clock samples is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| status_i | input | 8 | Live status bits shown in the monitor byte (bit 2 unused) |
| run_a_o | output | 1 | Converter-run bit of setpoint A (register 0 bit 7) |
| code_a_o | output | 7 | Voltage code of setpoint A |
| run_b_o | output | 1 | Converter-run bit of setpoint B (register 1 bit 7) |
| code_b_o | output | 7 | Voltage code of setpoint B |
| dischg_o | output | 1 | Output discharge enable |
| ramp_o | output | 3 | Ramp-rate code for rising transitions |
| mode_o | output | 2 | Mode bits |

## Verification
The checks assume that the master changes SDA only while SCL is low, except for START and STOP edges. They also assume that every bus level is held for longer than the synchronizer plus filter delay, and that the master never issues START or STOP while the target is pulling SDA low. The stimulus keeps to these limits. Each quarter bit is ten system clocks, and the bench changes data only in the middle of the SCL low phase. The bench resolves the line as the wired-AND of the master drive and the target drive. The only short pulse in the stimulus is the one-clock SCL dip used for R10.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
    localparam logic [7:0] DEF_SET0 = 8'hD4;
    localparam logic [7:0] DEF_SET1 = 8'hCD;
    localparam logic [7:0] DEF_CTRL = 8'h80;
    localparam logic [7:0] DEF_ID_A = 8'h85;
    localparam logic [7:0] DEF_ID_B = 8'h00;

    localparam logic [7:0] IDX_SET0 = 8'd0;
    localparam logic [7:0] IDX_SET1 = 8'd1;
    localparam logic [7:0] IDX_CTRL = 8'd2;
    localparam logic [7:0] IDX_ID_A = 8'd3;
    localparam logic [7:0] IDX_ID_B = 8'd4;
    localparam logic [7:0] IDX_MON  = 8'd5;

    localparam int         CTRL_SRST_BIT = 2;
    localparam logic [7:0] CTRL_KEEP     = 8'hF3;  // bits 3 and 2 never stored
    localparam int         MON_FLAG_BIT  = 2;

    typedef enum logic [2:0] {
        PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_MACK, PH_HOLD
    } phase_e;

    typedef enum logic [1:0] {
        BY_ADDR, BY_PTR, BY_DATA
    } byte_e;
endpackage

// File: rtl/i2c_rf_filt.sv
module i2c_rf_filt #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [FILT_LEN-1:0]    hist;
        logic                   level;
    } filt_t;

    filt_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], line_i};
        s_d.hist = {s_q.hist[FILT_LEN-2:0], s_q.sync[SYNC_STAGES-1]};
        // level moves only once the whole window agrees
        if (&s_q.hist) begin
            s_d.level = 1'b1;
        end else if (~|s_q.hist) begin
            s_d.level = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_o = s_q.level;
endmodule

// File: rtl/i2c_rf_link.sv
module i2c_rf_link
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl,
    input  logic       sda,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       rd_en,
    output logic [7:0] rd_addr
);
    localparam int         BITS   = 8;
    localparam logic [3:0] LAST   = 4'(BITS);
    localparam logic [4:0] HS_PFX = 5'b00001;

    typedef struct packed {
        phase_e     ph;
        byte_e      kind;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] ptr;
        logic       go_tx;
        logic       scl_p;
        logic       sda_p;
    } link_t;

    link_t s_d, s_q;
    logic  rise, fall, start_c, stop_c;

    always_comb begin
        rise    = scl & ~s_q.scl_p;
        fall    = ~scl & s_q.scl_p;
        start_c = scl & s_q.scl_p & s_q.sda_p & ~sda;
        stop_c  = scl & s_q.scl_p & ~s_q.sda_p & sda;

        s_d       = s_q;
        s_d.scl_p = scl;
        s_d.sda_p = sda;
        wr_en     = 1'b0;
        rd_en     = 1'b0;
        wr_addr   = s_q.ptr;
        wr_data   = s_q.sh;
        rd_addr   = s_q.ptr;

        if (start_c) begin
            s_d.ph   = PH_RX;
            s_d.kind = BY_ADDR;
            s_d.cnt  = '0;
        end else if (stop_c) begin
            s_d.ph = PH_IDLE;
        end else begin
            case (s_q.ph)
                PH_RX: begin
                    if (rise) begin
                        s_d.sh  = {s_q.sh[6:0], sda};
                        s_d.cnt = s_q.cnt + 4'd1;
                    end else if (fall && s_q.cnt == LAST) begin
                        s_d.cnt   = '0;
                        s_d.ph    = PH_ACK;
                        s_d.go_tx = 1'b0;
                        case (s_q.kind)
                            BY_ADDR: begin
                                if (s_q.sh[7:3] == HS_PFX || s_q.sh[7:1] != DEV_ADDR) begin
                                    s_d.ph = PH_HOLD;
                                end else begin
                                    s_d.go_tx = s_q.sh[0];
                                    s_d.kind  = BY_PTR;
                                end
                            end
                            BY_PTR: begin
                                s_d.ptr  = s_q.sh;
                                s_d.kind = BY_DATA;
                            end
                            default: begin
                                wr_en   = 1'b1;
                                s_d.ptr = s_q.ptr + 8'd1;
                            end
                        endcase
                    end
                end
                PH_ACK: begin
                    if (fall) begin
                        s_d.cnt = '0;
                        if (s_q.go_tx) begin
                            s_d.ph  = PH_TX;
                            s_d.sh  = rd_data;
                            rd_en   = 1'b1;
                            s_d.ptr = s_q.ptr + 8'd1;
                        end else begin
                            s_d.ph = PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (rise) begin
                        s_d.cnt = s_q.cnt + 4'd1;
                    end else if (fall) begin
                        if (s_q.cnt == LAST) begin
                            s_d.ph  = PH_MACK;
                            s_d.cnt = '0;
                        end else begin
                            s_d.sh = {s_q.sh[6:0], 1'b1};
                        end
                    end
                end
                PH_MACK: begin
                    if (rise && sda) begin
                        s_d.ph = PH_HOLD;
                    end else if (fall) begin
                        s_d.ph  = PH_TX;
                        s_d.sh  = rd_data;
                        rd_en   = 1'b1;
                        s_d.ptr = s_q.ptr + 8'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, kind: BY_ADDR, cnt: '0, sh: '0, ptr: '0,
                     go_tx: 1'b0, scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_oe = (s_q.ph == PH_ACK) | ((s_q.ph == PH_TX) & ~s_q.sh[7]);
endmodule

// File: rtl/i2c_rf_regs.sv
module i2c_rf_regs
    import i2c_rf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic [7:0] rd_addr,
    input  logic [7:0] mon_i,
    output logic [7:0] rd_data,
    output logic       flag_o,
    output logic       run_a,
    output logic [6:0] code_a,
    output logic       run_b,
    output logic [6:0] code_b,
    output logic       dischg,
    output logic [2:0] ramp,
    output logic [1:0] mode
);
    typedef struct packed {
        logic [7:0] set0;
        logic [7:0] set1;
        logic [7:0] ctrl;
        logic       rflag;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rd_en && rd_addr == IDX_MON) begin
            s_d.rflag = 1'b0;
        end
        if (wr_en) begin
            case (wr_addr)
                IDX_SET0: s_d.set0 = wr_data;
                IDX_SET1: s_d.set1 = wr_data;
                IDX_CTRL: begin
                    if (wr_data[CTRL_SRST_BIT]) begin
                        s_d.set0  = DEF_SET0;
                        s_d.set1  = DEF_SET1;
                        s_d.ctrl  = DEF_CTRL;
                        s_d.rflag = 1'b1;
                    end else begin
                        s_d.ctrl = wr_data & CTRL_KEEP;
                    end
                end
                default: ;
            endcase
        end

        case (rd_addr)
            IDX_SET0: rd_data = s_q.set0;
            IDX_SET1: rd_data = s_q.set1;
            IDX_CTRL: rd_data = s_q.ctrl;
            IDX_ID_A: rd_data = DEF_ID_A;
            IDX_ID_B: rd_data = DEF_ID_B;
            IDX_MON:  rd_data = mon_i;
            default:  rd_data = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{set0: DEF_SET0, set1: DEF_SET1, ctrl: DEF_CTRL, rflag: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign flag_o = s_q.rflag;
    assign run_a  = s_q.set0[7];
    assign code_a = s_q.set0[6:0];
    assign run_b  = s_q.set1[7];
    assign code_b = s_q.set1[6:0];
    assign dischg = s_q.ctrl[7];
    assign ramp   = s_q.ctrl[6:4];
    assign mode   = s_q.ctrl[1:0];
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1100000,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [7:0] status_i,
    output logic       run_a_o,
    output logic [6:0] code_a_o,
    output logic       run_b_o,
    output logic [6:0] code_b_o,
    output logic       dischg_o,
    output logic [2:0] ramp_o,
    output logic [1:0] mode_o
);
    localparam int         LINES    = 2;
    localparam logic [7:0] FLAG_MSK = 8'(1 << MON_FLAG_BIT);

    logic [LINES-1:0] raw, filt;
    logic             scl_f, sda_f;
    logic             wr_en, rd_en, rflag;
    logic [7:0]       wr_addr, wr_data, rd_addr, rd_data, mon_byte;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        i2c_rf_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw[g]),
            .line_o (filt[g])
        );
    end

    assign scl_f    = filt[0];
    assign sda_f    = filt[1];
    assign mon_byte = (status_i & ~FLAG_MSK) | (rflag ? FLAG_MSK : 8'h00);

    i2c_rf_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (scl_f),
        .sda     (sda_f),
        .rd_data (rd_data),
        .sda_oe  (sda_oe_o),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr)
    );

    i2c_rf_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .mon_i   (mon_byte),
        .rd_data (rd_data),
        .flag_o  (rflag),
        .run_a   (run_a_o),
        .code_a  (code_a_o),
        .run_b   (run_b_o),
        .code_b  (code_b_o),
        .dischg  (dischg_o),
        .ramp    (ramp_o),
        .mode    (mode_o)
    );
endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker
    import i2c_rf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       sda_oe,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       rd_en,
    input logic [7:0] rd_addr,
    input logic       rflag,
    input logic       run_a,
    input logic [6:0] code_a,
    input logic       run_b,
    input logic [6:0] code_b,
    input logic       dischg,
    input logic [2:0] ramp,
    input logic [1:0] mode
);
    // R3: the target changes its drive only while the filtered clock is low
    assert_drive_in_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    // R2: a data byte for setpoint A shows up on its exported fields
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == IDX_SET0) |=> ({run_a, code_a} == $past(wr_data)));

    // R2: write and read strobes never coincide
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, rd_en}));

    // R6: writes at or above the read-only boundary leave every field alone
    assert_ro_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= IDX_ID_A) |=>
            $stable({run_a, code_a, run_b, code_b, dischg, ramp, mode, rflag}));

    // R7: the soft reset restores all writable fields and raises the flag
    assert_srst_defaults_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == IDX_CTRL && wr_data[CTRL_SRST_BIT]) |=>
            ({run_a, code_a} == DEF_SET0 && {run_b, code_b} == DEF_SET1 &&
             {dischg, ramp, 2'b00, mode} == DEF_CTRL && rflag));

    // R8: reading the monitor clears the flag
    assert_mon_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == IDX_MON) |=> !rflag);
endmodule

bind i2c_regfile_target i2c_rf_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .sda_oe  (sda_oe_o),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rflag   (rflag),
    .run_a   (run_a_o),
    .code_a  (code_a_o),
    .run_b   (run_b_o),
    .code_b  (code_b_o),
    .dischg  (dischg_o),
    .ramp    (ramp_o),
    .mode    (mode_o)
);

// File: tb/test_i2c_regfile_target.sv
module test_i2c_regfile_target;
    localparam int         CLK_PERIOD = 10;
    localparam int         QTR        = 10;
    localparam int         NVEC       = 14;
    localparam logic [6:0] DEV        = 7'b1100000;

    // {is_write, reg address, write data, expected read-back}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 8'h00, 8'h00, 8'hD4},
        {1'b0, 8'h01, 8'h00, 8'hCD},
        {1'b0, 8'h02, 8'h00, 8'h80},
        {1'b0, 8'h03, 8'h00, 8'h85},
        {1'b0, 8'h04, 8'h00, 8'h00},
        {1'b0, 8'h05, 8'h00, 8'h00},
        {1'b1, 8'h00, 8'h3A, 8'h3A},
        {1'b1, 8'h01, 8'hC1, 8'hC1},
        {1'b1, 8'h02, 8'h7B, 8'h73},
        {1'b1, 8'h03, 8'h00, 8'h85},
        {1'b1, 8'h04, 8'hFF, 8'h00},
        {1'b1, 8'h05, 8'hFF, 8'h00},
        {1'b1, 8'h09, 8'h55, 8'h00},
        {1'b0, 8'h40, 8'h00, 8'h00}
    };

    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic [7:0] status = 8'h00;
    logic sda_oe, sda_line, run_a, run_b, dischg;
    logic [6:0] code_a, code_b;
    logic [2:0] ramp;
    logic [1:0] mode;
    int n_chk = 0, n_bad = 0, oe_hits = 0;
    logic quiet = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_regfile_target i_i2c_regfile_target (
        .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_line),
        .sda_oe_o (sda_oe), .status_i (status),
        .run_a_o (run_a), .code_a_o (code_a), .run_b_o (run_b), .code_b_o (code_b),
        .dischg_o (dischg), .ramp_o (ramp), .mode_o (mode)
    );

    always @(posedge clk) if (quiet && sda_oe) oe_hits++;

    task automatic hold();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; hold();
        sda_m = 1'b0; hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b0; hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b1; hold(); hold();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold();
            scl_m = 1'b1; hold();
            if (glitch && i == 3) begin
                scl_m = 1'b0; @(negedge clk); scl_m = 1'b1;
            end
            hold();
            scl_m = 1'b0; hold();
        end
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        acked = !sda_line; hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold();
            scl_m = 1'b1; hold();
            b[i] = sda_line; hold();
            scl_m = 1'b0; hold();
        end
        sda_m = nack; hold();
        scl_m = 1'b1; hold(); hold();
        scl_m = 1'b0; hold();
        sda_m = 1'b1;
    endtask

    task automatic write_reg(input logic [7:0] ptr, input logic [7:0] d);
        bit a1, a2, a3;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, a1);
        send_byte(ptr, 1'b0, a2);
        send_byte(d, 1'b0, a3);
        bus_stop();
        check("R1 write acks", {29'd0, a1, a2, a3}, 32'd7);
    endtask

    task automatic read_reg(input logic [7:0] ptr, output logic [7:0] d);
        bit a1, a2, a3;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, a1);
        send_byte(ptr, 1'b0, a2);
        bus_rstart();
        send_byte({DEV, 1'b1}, 1'b0, a3);
        recv_byte(1'b1, d);
        bus_stop();
        check("R1 read acks", {29'd0, a1, a2, a3}, 32'd7);
    endtask

    function automatic logic [7:0] port_byte(input logic [7:0] a);
        case (a)
            8'h00:   return {run_a, code_a};
            8'h01:   return {run_b, code_b};
            default: return {dischg, ramp, 2'b00, mode};
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [24:0] v;
        logic [7:0]  rd, rd2;
        bit          a1, a2;
        string       tag;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R4: exported fields and line drive straight out of reset
        check("R4 reset set A", {24'd0, run_a, code_a}, 32'hD4);
        check("R4 reset set B", {24'd0, run_b, code_b}, 32'hCD);
        check("R4 reset ctrl",  {24'd0, dischg, ramp, 2'b00, mode}, 32'h80);
        check("R3 idle release", {31'd0, sda_oe}, 32'd0);

        for (int k = 0; k < NVEC; k++) begin
            v = VEC[k];
            if (!v[24])             tag = "R4 read";
            else if (v[23:16] <= 2) tag = "R2 write";
            else                    tag = "R6 ignored";
            if (v[24]) write_reg(v[23:16], v[15:8]);
            read_reg(v[23:16], rd);
            check(tag, {24'd0, rd}, {24'd0, v[7:0]});
            if (v[24] && v[23:16] <= 2)
                check("R2 ports", {24'd0, port_byte(v[23:16])}, {24'd0, v[7:0]});
        end

        // R1: another address gets no ACK and its bytes do nothing
        quiet = 1'b1; oe_hits = 0;
        bus_start();
        send_byte({7'b1100001, 1'b0}, 1'b0, a1);
        send_byte(8'h00, 1'b0, a2);
        send_byte(8'hEE, 1'b0, a2);
        bus_stop();
        quiet = 1'b0;
        check("R1 foreign address nack", {31'd0, a1}, 32'd0);
        check("R1 foreign address silent", oe_hits, 32'd0);
        read_reg(8'h00, rd);
        check("R1 foreign address no write", {24'd0, rd}, 32'h3A);

        // R9: high-speed master code is not acknowledged, trailing bytes ignored
        quiet = 1'b1; oe_hits = 0;
        bus_start();
        send_byte(8'h0D, 1'b0, a1);
        send_byte(8'h00, 1'b0, a2);
        send_byte(8'hEE, 1'b0, a2);
        bus_stop();
        quiet = 1'b0;
        check("R9 master code nack", {31'd0, a1}, 32'd0);
        check("R9 master code silent", oe_hits, 32'd0);
        read_reg(8'h00, rd);
        check("R9 no write", {24'd0, rd}, 32'h3A);

        // R5: two data bytes land in consecutive registers
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, a1);
        send_byte(8'h00, 1'b0, a1);
        send_byte(8'h11, 1'b0, a1);
        send_byte(8'h22, 1'b0, a2);
        bus_stop();
        check("R5 burst write ack", {31'd0, a2}, 32'd1);
        read_reg(8'h00, rd);
        check("R5 burst write reg0", {24'd0, rd}, 32'h11);
        read_reg(8'h01, rd);
        check("R5 burst write reg1", {24'd0, rd}, 32'h22);

        // R3 R5: burst read with master ACK then NACK
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, a1);
        send_byte(8'h00, 1'b0, a1);
        bus_rstart();
        send_byte({DEV, 1'b1}, 1'b0, a1);
        recv_byte(1'b0, rd);
        recv_byte(1'b1, rd2);
        bus_stop();
        check("R3 burst read byte0", {24'd0, rd}, 32'h11);
        check("R5 burst read byte1", {24'd0, rd2}, 32'h22);

        // R8: live status with input bit 2 masked
        status = 8'hA7;
        read_reg(8'h05, rd);
        check("R8 live status", {24'd0, rd}, 32'hA3);

        // R7: soft reset restores defaults
        write_reg(8'h02, 8'h04);
        check("R7 ports set A", {24'd0, run_a, code_a}, 32'hD4);
        check("R7 ports ctrl", {24'd0, dischg, ramp, 2'b00, mode}, 32'h80);
        read_reg(8'h02, rd);
        check("R7 ctrl readback", {24'd0, rd}, 32'h80);
        read_reg(8'h01, rd);
        check("R7 set B restored", {24'd0, rd}, 32'hCD);

        // R8: flag seen once, cleared by the read
        read_reg(8'h05, rd);
        check("R8 flag set", {24'd0, rd}, 32'hA7);
        read_reg(8'h05, rd);
        check("R8 flag cleared", {24'd0, rd}, 32'hA3);

        // R10: a one-sample SCL dip inside a data bit is filtered out
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, a1);
        send_byte(8'h01, 1'b0, a1);
        send_byte(8'h5A, 1'b1, a2);
        bus_stop();
        check("R10 glitch ack", {31'd0, a2}, 32'd1);
        read_reg(8'h01, rd);
        check("R10 glitch data", {24'd0, rd}, 32'h5A);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule